// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A request gives the virtual address, an access type (read or write) and a root register that holds the base of the top-level table. Only this register changes on a context switch. The walker reads a directory entry, then a leaf entry, through a memory port that has one transaction in flight at a time.

It checks the present bit at both levels and the writable bit on writes. When an access succeeds it sets the referenced bit in the leaf entry, and on a write it also sets the modified bit. It writes the leaf entry back to memory only when one of those bits actually changes. The walk ends with a one-cycle completion pulse that carries a result code. On success it also returns the physical address and the entry's attribute bits.

Table entries are 32 bits: frame number in [31:12], cache-disable [4], modified [3], referenced [2], writable [1], present [0]. Virtual addresses split into a directory index [31:22], a leaf index [21:12] and a page offset [11:0], with 4 KB pages.

Top module: `ptw_walker`

## Requirements
- R1: The directory entry is read from {root_base[31:12], 12'h000} + vaddr[31:22]*4. The low 12 bits of root_base are ignored.
- R2: If the directory entry is present, the leaf entry is read from {dir_entry[31:12], 12'h000} + vaddr[21:12]*4.
- R3: A directory entry with present (bit 0) clear ends the walk with result 1 (page fault) after exactly one memory access.
- R4: A leaf entry with present clear ends the walk with result 1, and nothing is written.
- R5: A write access to a present leaf with writable (bit 1) clear ends the walk with result 2 (protection fault), and nothing is written.
- R6: On result 0 (ok), paddr is {leaf[31:12], vaddr[11:0]} and attr is bits [4:0] of the leaf entry after update.
- R7: On success, the updated entry is the leaf entry with bit 2 set, and also bit 3 set for a write. It is written back to the leaf address before completion only if it differs from the stored entry.
- R8: done is high for exactly one cycle per accepted request. result is 0 ok, 1 page fault or 2 protection fault. On a fault, paddr and attr read zero.
- R9: start is accepted only while busy is low. A start pulse during a walk is ignored and does not change the walk in progress.
- R10: mem_req stays high with stable mem_addr, mem_we and mem_wdata until mem_ack is seen. mem_we is high only for the write-back.
- R11: After reset the walker is idle: busy, done and mem_req are low.
- R12: root_base, vaddr and is_write are sampled when start is accepted, so successive walks may use different roots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_base | input | 32 | Base address of the top-level table |
| start | input | 1 | Request strobe, taken when idle |
| vaddr | input | 32 | Virtual address to translate |
| is_write | input | 1 | 1 for a write access, 0 for a read |
| busy | output | 1 | High from acceptance until after completion |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 page fault, 2 protection fault |
| paddr | output | 32 | Physical address (valid with done, result 0) |
| attr | output | 5 | Updated leaf bits [4:0] (valid with done, result 0) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench goes after the write-back rules. It covers a first read that must set referenced, a repeat read that must stay silent, a first write that must set modified, and a repeat write that must not touch memory. A walker that always writes back, or that never does, shows up as an unexpected or a missing memory transaction. A protection fault on a read-only page is followed by a read of the same page. A walker that updated status bits on the fault would then skip the later write-back. Other cases are a missing directory entry, which must stop after one read, the all-ones address at the far edge of both tables, a root with stray low bits, a root swap for the same virtual address, and a start pulse injected mid-walk, which must not cause a second completion.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PTE_W  = 32;
  localparam int ATTR_W = 5;
  localparam int BIT_P  = 0;
  localparam int BIT_W  = 1;
  localparam int BIT_R  = 2;
  localparam int BIT_M  = 3;
  localparam int BIT_CD = 4;

  typedef enum logic [1:0] {
    RES_OK         = 2'd0,
    RES_PAGE_FAULT = 2'd1,
    RES_PROT_FAULT = 2'd2
  } walk_res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TOP,
    ST_LEAF,
    ST_UPD,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/ptw_addr.sv
module ptw_addr #(
  parameter int PT1_W = 10,
  parameter int PT2_W = 10,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input  logic [PT1_W+PT2_W+OFF_W-1:0] va,
  input  logic [PA_W-OFF_W-1:0]        root_frame,
  input  logic [PA_W-OFF_W-1:0]        dir_frame,
  output logic [PA_W-1:0]              top_addr,
  output logic [PA_W-1:0]              leaf_addr,
  output logic [OFF_W-1:0]             offset
);
  localparam int VA_W = PT1_W + PT2_W + OFF_W;

  logic [PT1_W-1:0] pt1;
  logic [PT2_W-1:0] pt2;

  always_comb begin
    pt1       = va[VA_W-1 -: PT1_W];
    pt2       = va[OFF_W +: PT2_W];
    offset    = va[OFF_W-1:0];
    top_addr  = {root_frame, {OFF_W{1'b0}}} + (PA_W'(pt1) << 2);
    leaf_addr = {dir_frame,  {OFF_W{1'b0}}} + (PA_W'(pt2) << 2);
  end
endmodule

// File: rtl/ptw_check.sv
module ptw_check
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] entry,
  input  logic             is_wr,
  output logic             present,
  output logic             wr_ok,
  output logic [PTE_W-1:0] upd,
  output logic             wb_need
);
  always_comb begin
    present = entry[BIT_P];
    wr_ok   = entry[BIT_W];
    upd     = entry;
    upd[BIT_R] = 1'b1;
    if (is_wr) upd[BIT_M] = 1'b1;
    wb_need = (upd != entry);
  end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic      clk,
  input  logic      arst_n,
  input  logic      start,
  input  logic      mem_ack,
  input  logic      is_wr,
  input  logic      top_present,
  input  logic      leaf_present,
  input  logic      leaf_wr_ok,
  input  logic      leaf_wb_need,
  output walk_st_e  state_q,
  output logic      fin_set,
  output walk_res_e fin_code
);
  walk_st_e state_d;

  always_comb begin
    state_d  = state_q;
    fin_set  = 1'b0;
    fin_code = RES_OK;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_TOP;
      ST_TOP: begin
        if (mem_ack) begin
          if (top_present) begin
            state_d = ST_LEAF;
          end else begin
            state_d  = ST_DONE;
            fin_set  = 1'b1;
            fin_code = RES_PAGE_FAULT;
          end
        end
      end
      ST_LEAF: begin
        if (mem_ack) begin
          if (!leaf_present) begin
            state_d  = ST_DONE;
            fin_set  = 1'b1;
            fin_code = RES_PAGE_FAULT;
          end else if (is_wr && !leaf_wr_ok) begin
            state_d  = ST_DONE;
            fin_set  = 1'b1;
            fin_code = RES_PROT_FAULT;
          end else if (leaf_wb_need) begin
            state_d = ST_UPD;
          end else begin
            state_d  = ST_DONE;
            fin_set  = 1'b1;
            fin_code = RES_OK;
          end
        end
      end
      ST_UPD: begin
        if (mem_ack) begin
          state_d  = ST_DONE;
          fin_set  = 1'b1;
          fin_code = RES_OK;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int PT1_W = 10,
  parameter int PT2_W = 10,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PA_W-1:0]             root_base,
  input  logic                        start,
  input  logic [PT1_W+PT2_W+OFF_W-1:0] vaddr,
  input  logic                        is_write,
  output logic                        busy,
  output logic                        done,
  output logic [1:0]                  result,
  output logic [PA_W-1:0]             paddr,
  output logic [ATTR_W-1:0]           attr,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [PA_W-1:0]             mem_addr,
  output logic [PTE_W-1:0]            mem_wdata,
  input  logic                        mem_ack,
  input  logic [PTE_W-1:0]            mem_rdata
);
  localparam int VA_W  = PT1_W + PT2_W + OFF_W;
  localparam int FRM_W = PA_W - OFF_W;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign arst_n = rst_sync_q[1];

  walk_st_e   state_q;
  logic       fin_set;
  walk_res_e  fin_code;
  logic       accept;

  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [FRM_W-1:0] root_q;
  logic [FRM_W-1:0] dir_q;
  logic [PTE_W-1:0] ent_q;
  logic [1:0]       res_q;
  logic [PA_W-1:0]  pa_q;
  logic [ATTR_W-1:0] attr_q;

  logic [PA_W-1:0]  top_addr;
  logic [PA_W-1:0]  leaf_addr;
  logic [OFF_W-1:0] offset;
  logic             chk_present;
  logic             chk_wr_ok;
  logic [PTE_W-1:0] chk_upd;
  logic             chk_wb_need;
  logic [PTE_W-1:0] fin_ent;

  assign accept = start && (state_q == ST_IDLE);

  ptw_addr #(
    .PT1_W(PT1_W), .PT2_W(PT2_W), .OFF_W(OFF_W), .PA_W(PA_W)
  ) u_addr (
    .va        (va_q),
    .root_frame(root_q),
    .dir_frame (dir_q),
    .top_addr  (top_addr),
    .leaf_addr (leaf_addr),
    .offset    (offset)
  );

  ptw_check u_check (
    .entry  (mem_rdata),
    .is_wr  (wr_q),
    .present(chk_present),
    .wr_ok  (chk_wr_ok),
    .upd    (chk_upd),
    .wb_need(chk_wb_need)
  );

  ptw_fsm u_fsm (
    .clk         (clk),
    .arst_n      (arst_n),
    .start       (start),
    .mem_ack     (mem_ack),
    .is_wr       (wr_q),
    .top_present (mem_rdata[BIT_P]),
    .leaf_present(chk_present),
    .leaf_wr_ok  (chk_wr_ok),
    .leaf_wb_need(chk_wb_need),
    .state_q     (state_q),
    .fin_set     (fin_set),
    .fin_code    (fin_code)
  );

  // request capture
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      va_q   <= '0;
      wr_q   <= 1'b0;
      root_q <= '0;
    end else if (accept) begin
      va_q   <= vaddr;
      wr_q   <= is_write;
      root_q <= root_base[PA_W-1 -: FRM_W];
    end
  end

  // directory frame capture
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                              dir_q <= '0;
    else if (state_q == ST_TOP && mem_ack)    dir_q <= mem_rdata[PTE_W-1 -: FRM_W];
  end

  // updated leaf entry, held for the write-back
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                              ent_q <= '0;
    else if (state_q == ST_LEAF && mem_ack)   ent_q <= chk_upd;
  end

  assign fin_ent = (state_q == ST_UPD) ? ent_q : chk_upd;

  // completion registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      res_q  <= '0;
      pa_q   <= '0;
      attr_q <= '0;
    end else if (fin_set) begin
      res_q <= fin_code;
      if (fin_code == RES_OK) begin
        pa_q   <= {fin_ent[PTE_W-1 -: FRM_W], offset};
        attr_q <= fin_ent[ATTR_W-1:0];
      end else begin
        pa_q   <= '0;
        attr_q <= '0;
      end
    end
  end

  always_comb begin
    busy      = (state_q != ST_IDLE);
    done      = (state_q == ST_DONE);
    result    = res_q;
    paddr     = pa_q;
    attr      = attr_q;
    mem_req   = (state_q == ST_TOP) || (state_q == ST_LEAF) || (state_q == ST_UPD);
    mem_we    = (state_q == ST_UPD);
    mem_wdata = (state_q == ST_UPD) ? ent_q : '0;
    case (state_q)
      ST_TOP:          mem_addr = top_addr;
      ST_LEAF, ST_UPD: mem_addr = leaf_addr;
      default:         mem_addr = '0;
    endcase
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [1:0]  result,
  input logic [31:0] paddr,
  input logic [4:0]  attr,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_RESULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result != 2'd3); // R8
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done && result != 2'd0 |-> paddr == 32'd0 && attr == 5'd0); // R8
  AST_OK_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
    done && result == 2'd0 |-> attr[0] && attr[2]); // R6
  AST_WB_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[0] && mem_wdata[2]); // R7
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy && !done); // R9
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .result   (result),
  .paddr    (paddr),
  .attr     (attr),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_ack  (mem_ack)
);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] root_base = '0;
  logic        start = 1'b0;
  logic [31:0] vaddr = '0;
  logic        is_write = 1'b0;
  logic        busy, done;
  logic [1:0]  result;
  logic [31:0] paddr;
  logic [4:0]  attr;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #10 clk = ~clk;

  ptw_walker u_ptw_walker (
    .clk(clk), .rst_n(rst_n), .root_base(root_base), .start(start),
    .vaddr(vaddr), .is_write(is_write), .busy(busy), .done(done),
    .result(result), .paddr(paddr), .attr(attr), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit expired = 0;

  logic [31:0] mem [int unsigned];
  int lat = 0;
  int wcnt = 0;

  logic [31:0] q_addr[$];
  logic        q_we[$];
  logic [31:0] q_wd[$];
  string       q_tag[$];
  bit          exp_pending = 0;
  logic [1:0]  exp_res;
  logic [31:0] exp_pa;
  logic [4:0]  exp_attr;
  string       exp_tag;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference walk: queues the accesses and the completion it implies
  task automatic build(input logic [31:0] root, input logic [31:0] va,
                       input logic wr, input string tag);
    logic [31:0] a1, d, a2, lf, nw;
    a1 = {root[31:12], 12'h0} + {20'h0, va[31:22], 2'b00};
    q_addr.push_back(a1); q_we.push_back(1'b0); q_wd.push_back(32'h0); q_tag.push_back("R1");
    d = rd(a1);
    exp_tag = tag; exp_pa = 0; exp_attr = 0;
    if (!d[0]) begin exp_res = 2'd1; return; end
    a2 = {d[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
    q_addr.push_back(a2); q_we.push_back(1'b0); q_wd.push_back(32'h0); q_tag.push_back("R2");
    lf = rd(a2);
    if (!lf[0]) begin exp_res = 2'd1; return; end
    if (wr && !lf[1]) begin exp_res = 2'd2; return; end
    nw = lf | 32'h4 | (wr ? 32'h8 : 32'h0);
    if (nw != lf) begin
      q_addr.push_back(a2); q_we.push_back(1'b1); q_wd.push_back(nw); q_tag.push_back("R7");
    end
    exp_res = 2'd0; exp_pa = {nw[31:12], va[11:0]}; exp_attr = nw[4:0];
  endtask

  // memory responder and per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_ack) begin
        mem_ack = 1'b0;
        wcnt = 0;
      end else if (mem_req) begin
        if (wcnt >= lat) begin
          if (q_addr.size() == 0) begin
            chk(1'b0, "R10", "unexpected access addr", mem_addr, 32'h0);
          end else begin
            automatic logic [31:0] ea = q_addr.pop_front();
            automatic logic        ew = q_we.pop_front();
            automatic logic [31:0] ed = q_wd.pop_front();
            automatic string       et = q_tag.pop_front();
            chk(mem_addr == ea, et, "access addr", mem_addr, ea);
            chk(mem_we == ew, et, "access we", {31'h0, mem_we}, {31'h0, ew});
            if (ew) chk(mem_wdata == ed, et, "write data", mem_wdata, ed);
          end
          if (mem_we) mem[mem_addr] = mem_wdata;
          else        mem_rdata = rd(mem_addr);
          mem_ack = 1'b1;
        end else begin
          wcnt++;
        end
      end
      if (done) begin
        if (!exp_pending) begin
          chk(1'b0, "R8", "unexpected done", 32'h1, 32'h0);
        end else begin
          chk(result == exp_res, exp_tag, "result", {30'h0, result}, {30'h0, exp_res});
          chk(paddr == exp_pa, exp_tag, "paddr", paddr, exp_pa);
          chk(attr == exp_attr, exp_tag, "attr", {27'h0, attr}, {27'h0, exp_attr});
          chk(q_addr.size() == 0, exp_tag, "accesses left at done",
              q_addr.size(), 32'h0);
          exp_pending = 0;
        end
      end
    end
  end

  task automatic walk(input logic [31:0] root, input logic [31:0] va, input logic wr,
                      input int latency, input string tag, input bit poke);
    while (busy && !expired) @(negedge clk);
    build(root, va, wr, tag);
    exp_pending = 1;
    lat = latency;
    root_base = root; vaddr = va; is_write = wr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: a start while busy must be ignored
      @(negedge clk);
      root_base = ~root; vaddr = ~va; is_write = ~wr; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_pending && !expired) @(negedge clk);
    @(negedge clk);
    chk(q_addr.size() == 0, tag, "missing accesses", q_addr.size(), 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !expired) begin
        expired = 1;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    // tables under root A = 0x10000 and root B = 0x20000
    mem[32'h0001_0004] = 32'h0003_0001;
    mem[32'h0003_0008] = 32'h0ABC_D003;
    mem[32'h0003_000C] = 32'h1234_5010;
    mem[32'h0003_0010] = 32'h0055_5011;
    mem[32'h0001_0FFC] = 32'h0004_0001;
    mem[32'h0004_0FFC] = 32'hFFFF_F00F;
    mem[32'h0002_0004] = 32'h0005_0001;
    mem[32'h0005_0008] = 32'h0777_7007;

    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R11", "idle during reset",
        {29'h0, busy, done, mem_req}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !mem_req, "R11", "idle after reset",
        {29'h0, busy, done, mem_req}, 32'h0);

    walk(32'h0001_0000, 32'h0040_2004, 1'b0, 0, "R6", 0); // first read sets referenced
    walk(32'h0001_0000, 32'h0040_2ABC, 1'b0, 1, "R7", 0); // repeat read, no write-back
    walk(32'h0001_0000, 32'h0040_2010, 1'b1, 2, "R7", 0); // first write sets modified
    walk(32'h0001_0000, 32'h0040_2FFF, 1'b1, 0, "R7", 0); // repeat write, silent
    walk(32'h0001_0000, 32'h0140_2000, 1'b0, 1, "R3", 0); // directory missing
    walk(32'h0001_0000, 32'h0040_3000, 1'b1, 2, "R4", 0); // leaf missing
    walk(32'h0001_0000, 32'h0040_4123, 1'b1, 1, "R5", 0); // write to read-only
    walk(32'h0001_0000, 32'h0040_4123, 1'b0, 0, "R5", 0); // fault left bits unchanged
    walk(32'h0001_0ABC, 32'hFFFF_FFFF, 1'b0, 3, "R1", 0); // stray root bits, far edge
    walk(32'h0002_0000, 32'h0040_2004, 1'b0, 1, "R12", 0); // other root
    walk(32'h0001_0000, 32'h0040_2008, 1'b0, 3, "R9", 1);  // start poked mid-walk
    walk(32'h0001_0000, 32'h0040_2008, 1'b1, 2, "R2", 0);
    repeat (5) @(negedge clk);
    chk(!busy && !done && !mem_req, "R8", "quiet after last walk",
        {29'h0, busy, done, mem_req}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule